// File: doc/BRIEF.md
# Flash Region Access Protection Checker

This block sits between the bus side of an on-chip flash and the flash controller and rules on every access request in the same cycle. Each request has a byte address and a kind: instruction fetch, data read, program or erase. Two protection maps decide the outcome. A fine map holds one read-enable bit per 2KB region. A coarse map holds one program-enable bit per 16KB region. A blocked data read raises a bus fault. A blocked program or erase is suppressed, and it raises a violation interrupt only when the interrupt mask input allows it. An instruction fetch is always granted. Because of this, a region with both bits cleared can be executed but not read, written or erased.

Each map has a working copy and a committed copy. Software can only clear working bits. A write ANDs the written word into the working copy, so a 1 in the word keeps the current bit and a 0 clears it. A commit strobe copies the working map into the committed map, and that makes the cleared bits permanent. A simulated power-on-reset strobe throws away uncommitted clears by reloading the working map from the committed map. Only the true asynchronous reset sets both copies back to all ones.

Top module: `flash_prot_checker`

## Requirements
- R1: After the true reset (rst_ni low), every bit of rd_en_o (128 bits) and pg_en_o (16 bits) reads 1, including bits that were committed as cleared before.
- R2: A valid request with req_type_i = 2'b00 (fetch) is always granted and never raises bus_fault_o or viol_irq_o.
- R3: A valid request with req_type_i = 2'b01 (data read) is granted when rd_en_o[req_addr_i[17:11]] is 1. Otherwise grant_o is 0 and bus_fault_o is 1 in the same cycle.
- R4: A valid request with req_type_i = 2'b10 (program) or 2'b11 (erase) is granted when pg_en_o[req_addr_i[17:14]] is 1. Otherwise grant_o is 0, and this never depends on rd_en_o.
- R5: A blocked program or erase raises viol_irq_o only while irq_mask_i is 1. It never raises bus_fault_o.
- R6: While req_valid_i is 0, grant_o, bus_fault_o and viol_irq_o are all 0.
- R7: A write (rd_wr_en_i or pg_wr_en_i) sets the working map to its current value ANDed with the write data, visible on rd_en_o/pg_en_o after the next clock edge. A cleared bit is never set again by a write.
- R8: A sim_por_i pulse reloads both working maps from their committed copies after the clock edge. Any write and any commit in the same cycle is ignored.
- R9: A commit_i pulse (without sim_por_i) copies the working maps as they stood before that edge into the committed copies. A write in the same cycle still reaches the working map but is not committed.
- R10: The two maps act independently on one address. With only the program bit clear, fetch and read are granted and program and erase are blocked. With only the read bit clear, program, erase and fetch are granted and read faults. With both clear, only fetch is granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous true reset |
| req_valid_i | input | 1 | Access request present |
| req_addr_i | input | 18 | Byte address within the flash |
| req_type_i | input | 2 | 00 fetch, 01 data read, 10 program, 11 erase |
| irq_mask_i | input | 1 | Enables the violation interrupt for blocked program/erase |
| grant_o | output | 1 | Access allowed |
| bus_fault_o | output | 1 | Blocked data read |
| viol_irq_o | output | 1 | Blocked program/erase with interrupt enabled |
| rd_wr_en_i | input | 1 | Apply rd_wr_data_i to the read-enable working map |
| rd_wr_data_i | input | 128 | AND mask for the read-enable map |
| pg_wr_en_i | input | 1 | Apply pg_wr_data_i to the program-enable working map |
| pg_wr_data_i | input | 16 | AND mask for the program-enable map |
| commit_i | input | 1 | Make the working maps permanent |
| sim_por_i | input | 1 | Reload the working maps from the committed copies |
| rd_en_o | output | 128 | Working read-enable map |
| pg_en_o | output | 16 | Working program-enable map |

## Verification
The assertions assume req_type_i and req_addr_i are known whenever req_valid_i is high. They also assume commit_i and sim_por_i are single-cycle strobes. The clear-only property holds only for cycles without sim_por_i, because that strobe may legitimately raise working bits back to their committed value. The bench drives every input on the falling edge and pulses each strobe for exactly one cycle. It places sim_por_i with a write or a commit in the same cycle only on purpose, to check the R8 priority.

// File: rtl/flash_prot_pkg.sv
package flash_prot_pkg;
  typedef enum logic [1:0] {
    ACC_FETCH = 2'b00,
    ACC_READ  = 2'b01,
    ACC_PROG  = 2'b10,
    ACC_ERASE = 2'b11
  } acc_e;
endpackage

// File: rtl/prot_map.sv
module prot_map #(
  parameter int NBITS = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [NBITS-1:0] wr_data_i,
  input  logic             commit_i,
  input  logic             sim_por_i,
  output logic [NBITS-1:0] en_o
);
  logic [NBITS-1:0] work_q, keep_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      work_q <= '1;
      keep_q <= '1;
    end else if (sim_por_i) begin
      work_q <= keep_q;
    end else begin
      if (commit_i) keep_q <= work_q;  // pre-write value
      if (wr_en_i)  work_q <= work_q & wr_data_i;
    end
  end

  assign en_o = work_q;
endmodule

// File: rtl/prot_policy.sv
module prot_policy
  import flash_prot_pkg::*;
(
  input  logic       valid_i,
  input  logic [1:0] type_i,
  input  logic       rd_bit_i,
  input  logic       pg_bit_i,
  input  logic       irq_mask_i,
  output logic       grant_o,
  output logic       fault_o,
  output logic       irq_o
);
  acc_e kind;
  logic allow;

  always_comb begin
    kind = acc_e'(type_i);
    unique case (kind)
      ACC_FETCH:          allow = 1'b1;
      ACC_READ:           allow = rd_bit_i;
      ACC_PROG, ACC_ERASE: allow = pg_bit_i;
      default:            allow = 1'b0;
    endcase
    grant_o = valid_i & allow;
    fault_o = valid_i & ~allow & (kind == ACC_READ);
    irq_o   = valid_i & ~allow & irq_mask_i & ((kind == ACC_PROG) | (kind == ACC_ERASE));
  end
endmodule

// File: rtl/flash_prot_checker.sv
module flash_prot_checker #(
  parameter  int FLASH_KB = 256,
  parameter  int RD_KB    = 2,
  parameter  int PG_KB    = 16,
  localparam int ADDR_W   = $clog2(FLASH_KB * 1024),
  localparam int RD_SHIFT = $clog2(RD_KB * 1024),
  localparam int PG_SHIFT = $clog2(PG_KB * 1024),
  localparam int N_RD     = FLASH_KB / RD_KB,
  localparam int N_PG     = FLASH_KB / PG_KB
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [1:0]        req_type_i,
  input  logic              irq_mask_i,
  output logic              grant_o,
  output logic              bus_fault_o,
  output logic              viol_irq_o,
  input  logic              rd_wr_en_i,
  input  logic [N_RD-1:0]   rd_wr_data_i,
  input  logic              pg_wr_en_i,
  input  logic [N_PG-1:0]   pg_wr_data_i,
  input  logic              commit_i,
  input  logic              sim_por_i,
  output logic [N_RD-1:0]   rd_en_o,
  output logic [N_PG-1:0]   pg_en_o
);
  localparam int RD_IDX_W = ADDR_W - RD_SHIFT;
  localparam int PG_IDX_W = ADDR_W - PG_SHIFT;

  logic [RD_IDX_W-1:0] rd_idx;
  logic [PG_IDX_W-1:0] pg_idx;

  prot_map #(.NBITS(N_RD)) u_rd_map (
    .clk_i, .rst_ni,
    .wr_en_i(rd_wr_en_i), .wr_data_i(rd_wr_data_i),
    .commit_i, .sim_por_i, .en_o(rd_en_o)
  );

  prot_map #(.NBITS(N_PG)) u_pg_map (
    .clk_i, .rst_ni,
    .wr_en_i(pg_wr_en_i), .wr_data_i(pg_wr_data_i),
    .commit_i, .sim_por_i, .en_o(pg_en_o)
  );

  assign rd_idx = req_addr_i[ADDR_W-1:RD_SHIFT];
  assign pg_idx = req_addr_i[ADDR_W-1:PG_SHIFT];

  prot_policy u_policy (
    .valid_i(req_valid_i), .type_i(req_type_i),
    .rd_bit_i(rd_en_o[rd_idx]), .pg_bit_i(pg_en_o[pg_idx]),
    .irq_mask_i, .grant_o, .fault_o(bus_fault_o), .irq_o(viol_irq_o)
  );
endmodule

// File: rtl/flash_prot_checker_sva.sv
module flash_prot_checker_sva #(
  parameter int N_RD = 128,
  parameter int N_PG = 16
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            req_valid_i,
  input logic [1:0]      req_type_i,
  input logic            irq_mask_i,
  input logic            grant_o,
  input logic            bus_fault_o,
  input logic            viol_irq_o,
  input logic            sim_por_i,
  input logic [N_RD-1:0] rd_en_o,
  input logic [N_PG-1:0] pg_en_o
);
  p_fetch_granted_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_type_i == 2'b00) |-> (grant_o && !bus_fault_o && !viol_irq_o));

  p_fault_is_read_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_fault_o |-> (req_valid_i && req_type_i == 2'b01 && !grant_o));

  p_irq_masked_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    viol_irq_o |-> (irq_mask_i && req_valid_i && req_type_i[1] && !grant_o && !bus_fault_o));

  p_idle_quiet_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |-> (!grant_o && !bus_fault_o && !viol_irq_o));

  p_rd_clear_only_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sim_por_i |=> ((rd_en_o & ~$past(rd_en_o)) == '0));

  p_pg_clear_only_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sim_por_i |=> ((pg_en_o & ~$past(pg_en_o)) == '0));
endmodule

bind flash_prot_checker flash_prot_checker_sva #(.N_RD(N_RD), .N_PG(N_PG)) u_sva (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_valid_i(req_valid_i), .req_type_i(req_type_i),
  .irq_mask_i(irq_mask_i), .grant_o(grant_o), .bus_fault_o(bus_fault_o),
  .viol_irq_o(viol_irq_o), .sim_por_i(sim_por_i), .rd_en_o(rd_en_o), .pg_en_o(pg_en_o)
);

// File: tb/flash_prot_checker_bench.sv
module flash_prot_checker_bench;
  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         req_valid = 1'b0;
  logic [17:0]  req_addr = '0;
  logic [1:0]   req_type = 2'b00;
  logic         irq_mask = 1'b0;
  logic         grant, bus_fault, viol_irq;
  logic         rd_wr_en = 1'b0;
  logic [127:0] rd_wr_data = '1;
  logic         pg_wr_en = 1'b0;
  logic [15:0]  pg_wr_data = '1;
  logic         commit = 1'b0;
  logic         sim_por = 1'b0;
  logic [127:0] rd_en;
  logic [15:0]  pg_en;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_prot_checker u_flash_prot_checker (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_addr_i(req_addr),
    .req_type_i(req_type), .irq_mask_i(irq_mask), .grant_o(grant),
    .bus_fault_o(bus_fault), .viol_irq_o(viol_irq), .rd_wr_en_i(rd_wr_en),
    .rd_wr_data_i(rd_wr_data), .pg_wr_en_i(pg_wr_en), .pg_wr_data_i(pg_wr_data),
    .commit_i(commit), .sim_por_i(sim_por), .rd_en_o(rd_en), .pg_en_o(pg_en)
  );

  task automatic chk(string req, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // outputs packed {grant, fault, irq}
  task automatic probe(string req, logic [1:0] kind, logic [17:0] addr, logic [2:0] exp);
    @(negedge clk);
    req_valid = 1'b1; req_type = kind; req_addr = addr;
    #1;
    chk(req, {125'd0, grant, bus_fault, viol_irq}, {125'd0, exp});
    req_valid = 1'b0;
  endtask

  task automatic pulse(logic rw, logic [127:0] rd, logic pw, logic [15:0] pd, logic cm, logic sp);
    @(negedge clk);
    rd_wr_en = rw; rd_wr_data = rd; pg_wr_en = pw; pg_wr_data = pd; commit = cm; sim_por = sp;
    @(negedge clk);
    rd_wr_en = 1'b0; rd_wr_data = '1; pg_wr_en = 1'b0; pg_wr_data = '1; commit = 1'b0; sim_por = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1 rd map", rd_en, '1);
    chk("R1 pg map", {112'd0, pg_en}, {112'd0, 16'hFFFF});
    probe("R3 read open", 2'b01, 18'h3FFFF, 3'b100);
    probe("R4 program open", 2'b10, 18'h00010, 3'b100);
  endtask

  task automatic t_idle;
    @(negedge clk);
    req_valid = 1'b0; req_type = 2'b01; irq_mask = 1'b1; #1;
    chk("R6 idle", {125'd0, grant, bus_fault, viol_irq}, 128'd0);
    irq_mask = 1'b0;
  endtask

  task automatic t_read_protect;
    logic [127:0] m = '1;
    m[5] = 1'b0;
    pulse(1'b1, m, 1'b0, '1, 1'b0, 1'b0);
    chk("R7 rd clear", rd_en, m);
    probe("R3 read blocked", 2'b01, 18'd5 * 2048 + 18'd7, 3'b010);
    probe("R3 neighbour open", 2'b01, 18'd4 * 2048 + 18'd2047, 3'b100);
    probe("R2 fetch in read-locked", 2'b00, 18'd5 * 2048, 3'b100);
    probe("R10 program in read-locked", 2'b10, 18'd5 * 2048, 3'b100);
  endtask

  task automatic t_prog_protect;
    pulse(1'b0, '1, 1'b1, 16'hFFFB, 1'b0, 1'b0);
    chk("R7 pg clear", {112'd0, pg_en}, {112'd0, 16'hFFFB});
    irq_mask = 1'b0;
    probe("R5 program blocked no irq", 2'b10, 18'd2 * 16384 + 18'd100, 3'b000);
    irq_mask = 1'b1;
    probe("R5 erase blocked irq", 2'b11, 18'd2 * 16384 + 18'd100, 3'b001);
    probe("R10 read in read-only", 2'b01, 18'd2 * 16384 + 18'd100, 3'b100);
    probe("R4 other region program", 2'b10, 18'd3 * 16384, 3'b100);
    irq_mask = 1'b0;
  endtask

  task automatic t_no_set;
    logic [127:0] m = '1;
    m[5] = 1'b0;
    pulse(1'b1, '1, 1'b1, '1, 1'b0, 1'b0);
    chk("R7 rd stays clear", rd_en, m);
    chk("R7 pg stays clear", {112'd0, pg_en}, {112'd0, 16'hFFFB});
  endtask

  task automatic t_sim_por;
    pulse(1'b1, '0, 1'b1, '0, 1'b1, 1'b1);
    chk("R8 rd restored", rd_en, '1);
    chk("R8 pg restored", {112'd0, pg_en}, {112'd0, 16'hFFFF});
    probe("R8 read reopened", 2'b01, 18'd5 * 2048, 3'b100);
  endtask

  task automatic t_commit;
    logic [127:0] m9 = '1;
    logic [127:0] m10 = '1;
    m9[9] = 1'b0;
    m10[10] = 1'b0;
    pulse(1'b1, m9, 1'b0, '1, 1'b0, 1'b0);
    pulse(1'b1, m10, 1'b0, '1, 1'b1, 1'b0);
    chk("R9 working after commit+write", rd_en, m9 & m10);
    pulse(1'b0, '1, 1'b0, '1, 1'b0, 1'b1);
    chk("R9 committed kept, late write dropped", rd_en, m9);
    probe("R9 read still blocked", 2'b01, 18'd9 * 2048, 3'b010);
  endtask

  task automatic t_exec_only;
    logic [127:0] m = '1;
    m[31:24] = 8'h00;
    pulse(1'b1, m, 1'b1, 16'hFFF7, 1'b0, 1'b0);
    irq_mask = 1'b1;
    probe("R10 exec-only fetch", 2'b00, 18'd3 * 16384 + 18'd500, 3'b100);
    probe("R10 exec-only read", 2'b01, 18'd3 * 16384 + 18'd16383, 3'b010);
    probe("R10 exec-only program", 2'b10, 18'd3 * 16384, 3'b001);
    probe("R10 exec-only erase", 2'b11, 18'd3 * 16384 + 18'd9000, 3'b001);
    irq_mask = 1'b0;
  endtask

  task automatic t_true_reset;
    pulse(1'b0, '1, 1'b0, '1, 1'b1, 1'b0);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    #1;
    chk("R1 rd after true reset", rd_en, '1);
    chk("R1 pg after true reset", {112'd0, pg_en}, {112'd0, 16'hFFFF});
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_idle();
    t_read_protect();
    t_prog_protect();
    t_no_set();
    t_sim_por();
    t_commit();
    t_exec_only();
    t_true_reset();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule